// File: doc/BRIEF.md
# Page Entry Permission Checker

This block takes one leaf page-table entry, together with the kind of access being attempted and the privilege context of that access. It decides which of read, write and execute the entry grants. It then reports whether the requested access must fault, and sets a cause word that says why. Separately, it checks whether the entry's referenced and changed bits already cover the access. It raises a second fault flag when they do not. The block only reads these two bits and never writes them back.

The block sits after a table walker. The walker presents a leaf entry with a one-cycle valid strobe. One clock later the block returns the granted rights, the protection fault flag, the cause word and the reference/change fault flag, together with an output valid pulse. The results then hold until the next valid input.

Encodings used throughout:
- Access type: 2'b00 load, 2'b01 store, 2'b10 fetch, 2'b11 treated as a load.
- Rights vectors, both granted and mask: bit 2 read, bit 1 write, bit 0 execute.
- Entry fields: bit 8 referenced, bit 7 changed, bits 5:4 attribute (2'b10 is non-idempotent I/O), bit 3 privileged-only, bit 2 read, bit 1 read-write (grants read and write), bit 0 execute.
- Cause word: bit 28 is no-execute/guarded, bit 27 is protection.

Top module: `pte_perm_check`

## Requirements
- R1: After reset, outValid, grantRwx, protFault, causeWord and rcFault are all zero.
- R2: Each input accepted with inValid high produces results and a one-cycle outValid pulse on the next clock edge. When inValid is low, all result outputs hold their values and outValid is low.
- R3: A fetch (2'b10) of an entry whose attribute bits 5:4 equal 2'b10 faults before any other check. It gives protFault=1, causeWord with only bit 28 set, and grantRwx=0.
- R4: In a first-stage translation (secondStage=0), a privileged-only entry (bit 3) accessed while procUser=1 gets grantRwx=0.
- R5: Otherwise, when ctxUser=1, or the entry is privileged-only, or secondStage=1, grantRwx is taken from the entry bits alone: read = bit 2 or bit 1, write = bit 1, execute = bit 0. amrMask has no effect in this case.
- R6: In the remaining case (ctxUser=0, entry not privileged-only, first stage, procUser=0), grantRwx is the entry's rights ANDed bit by bit with amrMask.
- R7: A load needs read, a store needs write and a fetch needs execute. A missing right gives protFault=1. A fetch then sets cause bit 28 only, and a load or store sets cause bit 27 only. Without a fault, causeWord is zero.
- R8: rcFault is 1 for a store unless both bit 8 and bit 7 are set. For a load or fetch it is 1 unless bit 8 is set.
- R9: The I/O attribute does not by itself cause a fault on a load or store; those accesses follow R4 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input entry and context are valid this cycle |
| entry | input | 64 | Leaf page-table entry |
| accType | input | 2 | Access type: 00 load, 01 store, 10 fetch, 11 load |
| procUser | input | 1 | Processor is in problem (user) state |
| ctxUser | input | 1 | Translation context is a user context |
| secondStage | input | 1 | Entry belongs to the second-stage (partition) translation |
| amrMask | input | 3 | Authority mask, bit 2 read, bit 1 write, bit 0 execute |
| outValid | output | 1 | Results updated this cycle |
| grantRwx | output | 3 | Granted rights, bit 2 read, bit 1 write, bit 0 execute |
| protFault | output | 1 | Access is denied |
| causeWord | output | 32 | Fault cause, bit 28 no-execute/guarded, bit 27 protection |
| rcFault | output | 1 | Reference/change bits do not cover the access |

## Verification
The bench targets the following corner cases, and each one exposes a specific error:
- I/O-attribute fetch on a fully permitted page: a checker that orders the tests wrongly reports success, or sets the protection cause.
- The same attribute on a load: a checker that tests the attribute without looking at the access type faults a legal load.
- A user-mode access to a privileged-only page, in the first and in the second stage: a design that ignores the stage flag either grants rights to a user or denies a second-stage access.
- A kernel access restricted by the authority mask, and a user-context access with a zero mask: applying the mask in the wrong case either leaks rights or drops them.
- The reference/change combinations for each access type: these catch a store check that looks at only one of the two bits.

// File: rtl/pte_perm_pkg.sv
package pte_perm_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  localparam int BitRef   = 8;
  localparam int BitChg   = 7;
  localparam int AttHi    = 5;
  localparam int AttLo    = 4;
  localparam int BitPriv  = 3;
  localparam int BitRd    = 2;
  localparam int BitRw    = 1;
  localparam int BitEx    = 0;
  localparam logic [1:0] AttNonIdemIo = 2'b10;

  localparam int CauseNoExec = 28;
  localparam int CauseProt   = 27;

  typedef struct packed {
    logic capture;
  } strobe_t;
endpackage

// File: rtl/pte_perm_ctrl.sv
module pte_perm_ctrl
  import pte_perm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    outValid
);
  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R2: one output pulse per accepted input, one cycle later
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
endmodule

// File: rtl/pte_perm_dp.sv
module pte_perm_dp
  import pte_perm_pkg::*;
#(
  parameter int EntryW = 64,
  parameter int CauseW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [EntryW-1:0] entry,
  input  logic [1:0]        accType,
  input  logic              procUser,
  input  logic              ctxUser,
  input  logic              secondStage,
  input  logic [2:0]        amrMask,
  output logic [2:0]        grantRwx,
  output logic              protFault,
  output logic [CauseW-1:0] causeWord,
  output logic              rcFault
);
  logic       isFetch, isStore;
  logic       isIo, isPriv;
  logic [2:0] entryRwx, needRwx, grantNext;
  logic       faultNext, rcNext;
  logic [CauseW-1:0] causeNext;
  logic       unusedBits;

  assign unusedBits = ^{entry[EntryW-1:BitRef+1], entry[6]};

  assign isFetch  = (accType == ACC_FETCH);
  assign isStore  = (accType == ACC_STORE);
  assign isIo     = (entry[AttHi:AttLo] == AttNonIdemIo);
  assign isPriv   = entry[BitPriv];
  assign entryRwx = {entry[BitRd] | entry[BitRw], entry[BitRw], entry[BitEx]};
  assign needRwx  = isFetch ? 3'b001 : (isStore ? 3'b010 : 3'b100);

  always_comb begin
    grantNext = 3'b000;
    faultNext = 1'b0;
    causeNext = '0;
    if (isIo && isFetch) begin
      faultNext              = 1'b1;
      causeNext[CauseNoExec] = 1'b1;
    end else begin
      if (!secondStage && isPriv && procUser)
        grantNext = 3'b000;
      else if (ctxUser || isPriv || secondStage)
        grantNext = entryRwx;
      else
        grantNext = entryRwx & amrMask;
      if ((needRwx & ~grantNext) != 3'b000) begin
        faultNext = 1'b1;
        if (isFetch) causeNext[CauseNoExec] = 1'b1;
        else         causeNext[CauseProt]   = 1'b1;
      end
    end
  end

  always_comb begin
    if (isStore) rcNext = !(entry[BitRef] && entry[BitChg]);
    else         rcNext = !entry[BitRef];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grantRwx  <= 3'b000;
      protFault <= 1'b0;
      causeWord <= '0;
      rcFault   <= 1'b0;
    end else if (strobe.capture) begin
      grantRwx  <= grantNext;
      protFault <= faultNext;
      causeWord <= causeNext;
      rcFault   <= rcNext;
    end
  end

  // R3: I/O fetch faults with guarded cause and no rights
  a_r3_io_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && isFetch && isIo) |=>
      (protFault && grantRwx == 3'b000 && causeWord[CauseNoExec] && !causeWord[CauseProt]));
  // R4: privileged page, user mode, first stage gives nothing
  a_r4_priv_user_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && !secondStage && isPriv && procUser) |=> (grantRwx == 3'b000));
  // R7: cause is nonzero exactly when a fault is reported, one bit at most
  a_r7_cause_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (protFault == (causeWord != '0)) && $onehot0(causeWord));
  // R8: store without both bits must flag
  a_r8_store_rc: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && isStore && !(entry[BitRef] && entry[BitChg])) |=> rcFault);
  // R2: results hold while idle
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> ($stable(grantRwx) && $stable(causeWord) && $stable(rcFault)));
endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
  import pte_perm_pkg::*;
#(
  parameter int EntryW = 64,
  parameter int CauseW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [EntryW-1:0] entry,
  input  logic [1:0]        accType,
  input  logic              procUser,
  input  logic              ctxUser,
  input  logic              secondStage,
  input  logic [2:0]        amrMask,
  output logic              outValid,
  output logic [2:0]        grantRwx,
  output logic              protFault,
  output logic [CauseW-1:0] causeWord,
  output logic              rcFault
);
  strobe_t strobe;

  pte_perm_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pte_perm_dp #(.EntryW(EntryW), .CauseW(CauseW)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .entry       (entry),
    .accType     (accType),
    .procUser    (procUser),
    .ctxUser     (ctxUser),
    .secondStage (secondStage),
    .amrMask     (amrMask),
    .grantRwx    (grantRwx),
    .protFault   (protFault),
    .causeWord   (causeWord),
    .rcFault     (rcFault)
  );
endmodule

// File: tb/sim_pte_perm_check.sv
module sim_pte_perm_check;
  localparam int ClkPeriod = 10;
  localparam logic [31:0] CNoEx = 32'h1000_0000;
  localparam logic [31:0] CProt = 32'h0800_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] entry = '0;
  logic [1:0]  accType = 2'b00;
  logic        procUser = 1'b0, ctxUser = 1'b0, secondStage = 1'b0;
  logic [2:0]  amrMask = 3'b000;
  logic        outValid, protFault, rcFault;
  logic [2:0]  grantRwx;
  logic [31:0] causeWord;

  int total = 0;
  int bad = 0;

  always #(ClkPeriod/2) clk = ~clk;

  pte_perm_check u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .entry(entry), .accType(accType),
    .procUser(procUser), .ctxUser(ctxUser), .secondStage(secondStage), .amrMask(amrMask),
    .outValid(outValid), .grantRwx(grantRwx), .protFault(protFault),
    .causeWord(causeWord), .rcFault(rcFault)
  );

  function automatic logic [63:0] mkE(logic r, logic c, logic [1:0] att, logic pv,
                                      logic rd, logic rw, logic x);
    logic [63:0] e;
    e = '0;
    e[8] = r; e[7] = c; e[5:4] = att; e[3] = pv; e[2] = rd; e[1] = rw; e[0] = x;
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one entry, check results one cycle later, then check that they hold.
  task automatic run(string req, logic [63:0] e, logic [1:0] acc, logic pu, logic cu,
                     logic ss, logic [2:0] amr, logic [2:0] eg, logic ef,
                     logic [31:0] ec, logic erc);
    @(negedge clk);
    entry = e; accType = acc; procUser = pu; ctxUser = cu; secondStage = ss;
    amrMask = amr; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk({req, " R2 outValid"}, {31'b0, outValid}, 32'd1);
    chk({req, " grant"}, {29'b0, grantRwx}, {29'b0, eg});
    chk({req, " fault"}, {31'b0, protFault}, {31'b0, ef});
    chk({req, " cause"}, causeWord, ec);
    chk({req, " R8 rc"}, {31'b0, rcFault}, {31'b0, erc});
    entry = ~e; accType = ~acc; amrMask = ~amr; procUser = ~pu;
    @(negedge clk);
    chk({req, " R2 idle outValid"}, {31'b0, outValid}, 32'd0);
    chk({req, " R2 hold grant"}, {29'b0, grantRwx}, {29'b0, eg});
    chk({req, " R2 hold cause"}, causeWord, ec);
    chk({req, " R2 hold rc"}, {31'b0, rcFault}, {31'b0, erc});
  endtask

  task automatic t_reset();
    chk("R1 outValid", {31'b0, outValid}, 32'd0);
    chk("R1 grant", {29'b0, grantRwx}, 32'd0);
    chk("R1 fault", {31'b0, protFault}, 32'd0);
    chk("R1 cause", causeWord, 32'd0);
    chk("R1 rc", {31'b0, rcFault}, 32'd0);
  endtask

  task automatic t_io();
    run("R3 io fetch", mkE(1,1,2'b10,0,1,1,1), 2'b10, 0,0,0, 3'b111, 3'b000, 1, CNoEx, 0);
    run("R9 io load", mkE(1,0,2'b10,0,1,0,0), 2'b00, 0,0,0, 3'b111, 3'b100, 0, 32'd0, 0);
    run("R9 io store", mkE(1,1,2'b10,0,0,1,0), 2'b01, 0,1,0, 3'b000, 3'b110, 0, 32'd0, 0);
  endtask

  task automatic t_priv();
    run("R4 priv user", mkE(1,1,2'b00,1,0,1,1), 2'b00, 1,1,0, 3'b111, 3'b000, 1, CProt, 0);
    run("R5 priv user second", mkE(1,1,2'b00,1,0,1,1), 2'b00, 1,1,1, 3'b000, 3'b111, 0, 32'd0, 0);
    run("R5 priv kernel", mkE(1,1,2'b00,1,0,0,1), 2'b10, 0,0,0, 3'b000, 3'b001, 0, 32'd0, 0);
  endtask

  task automatic t_amr();
    run("R5 user ctx mask ignored", mkE(1,0,2'b00,0,1,0,0), 2'b00, 1,1,0, 3'b000, 3'b100, 0, 32'd0, 0);
    run("R6 kernel masked", mkE(1,1,2'b00,0,0,1,1), 2'b00, 0,0,0, 3'b001, 3'b001, 1, CProt, 0);
    run("R6 kernel masked ok", mkE(1,1,2'b00,0,0,1,1), 2'b01, 0,0,0, 3'b110, 3'b110, 0, 32'd0, 0);
  endtask

  task automatic t_need();
    run("R7 fetch no exec", mkE(1,0,2'b00,0,1,0,0), 2'b10, 1,1,0, 3'b111, 3'b100, 1, CNoEx, 0);
    run("R7 store read only", mkE(1,1,2'b00,0,1,0,0), 2'b01, 1,1,0, 3'b111, 3'b100, 1, CProt, 0);
    run("R7 code 11 as load", mkE(1,0,2'b00,0,0,0,1), 2'b11, 0,1,0, 3'b111, 3'b001, 1, CProt, 0);
  endtask

  task automatic t_rc();
    run("R8 store ref only", mkE(1,0,2'b00,0,0,1,0), 2'b01, 0,1,0, 3'b111, 3'b110, 0, 32'd0, 1);
    run("R8 store chg only", mkE(0,1,2'b00,0,0,1,0), 2'b01, 0,1,0, 3'b111, 3'b110, 0, 32'd0, 1);
    run("R8 load no ref", mkE(0,1,2'b00,0,1,0,0), 2'b00, 0,1,0, 3'b111, 3'b100, 0, 32'd0, 1);
    run("R8 load ref", mkE(1,0,2'b00,0,1,0,0), 2'b00, 0,1,0, 3'b111, 3'b100, 0, 32'd0, 0);
    run("R8 fetch no ref", mkE(0,0,2'b00,0,0,0,1), 2'b10, 0,1,0, 3'b111, 3'b001, 0, 32'd0, 1);
  endtask

  initial begin : watchdog
    #(ClkPeriod * 5000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_io();
    t_priv();
    t_amr();
    t_need();
    t_rc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule